// File: doc/BRIEF.md
# Low-Speed Time Base Counter

This block is a binary time base that counts ticks of a slow enable, nominally 256 Hz. Each bit of the count is a square-wave tap. Bit 0 runs at half the tick rate and bit 7 at 1/256 of it, so a 256 Hz tick gives taps from 128 Hz down to 1 Hz. Every tap is low for the first half of its period after a clear and high for the second half.

Software sees the taps through one register on a simple bus. A read returns the taps in the low byte, and the upper bits of the bus word always read zero. A write to the register clears every tap, and the data written is ignored. Each tap has an interrupt line that pulses for one cycle when the tap falls from 1 to 0, gated by its own enable bit. A clear that drops a tap that was high counts as a fall, so a clear can raise an interrupt. A reader in a faster clock domain must read twice and compare the two values, because a read can catch the count while it changes.

Top module: `tick_timebase`

## Requirements
- R1: After reset the count is 0x00, `rdData` is 0 and every `irqOut` bit is 0.
- R2: The count increases by one in each cycle where `tickEn` is high and no clear occurs, wrapping from 0xFF to 0x00. It holds when `tickEn` is low.
- R3: Register bit k is the tap whose period is 2^(k+1) ticks. Bit 7 first goes high 128 ticks after a clear, and bit 0 is the fastest tap.
- R4: A write (`wrEn` high, `addr` equal to `REG_ADDR`) with any `wrData` sets all taps to 0 at the next clock edge.
- R5: When a clear and a tick occur in the same cycle, the count is 0x00 after that edge.
- R6: A write to any other address leaves the count unchanged.
- R7: A read (`rdEn` high, `addr` equal to `REG_ADDR`) puts onto `rdData` at the next edge the count held before that edge. The count is in bits 7..0, and bits 15..8 are 0.
- R8: In a cycle after which no read to `REG_ADDR` took place, `rdData` is 0.
- R9: `irqOut[k]` is high for exactly one cycle after an edge where tap k goes from 1 to 0, provided `irqEn[k]` is high.
- R10: A clear that takes tap k from 1 to 0 raises `irqOut[k]` for one cycle when `irqEn[k]` is high.
- R11: While `irqEn[k]` is low, `irqOut[k]` stays 0 whatever the tap does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count-advance enable (256 Hz pulse) |
| addr | input | 16 | Register bus address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data (ignored; any write clears) |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Read data, valid the cycle after a read |
| irqEn | input | 8 | Per-tap interrupt enables |
| irqOut | output | 8 | Per-tap falling-edge interrupt pulses |

## Verification
The bench builds the block with its default values: eight taps, a 16-bit bus and the register at address 0x0040. With only 256 states, the bench can drive the count through the whole cycle more than once and read back every value. It sees every tap fall, including the step from 0xFF to 0x00 where all eight fall at once. The sweeps use three enable masks (all set, 0xA5 and all clear). Directed cases then cover a clear from a nonzero value, a clear in the same cycle as a tick, a write and a read to a wrong address, and a read in the same cycle as a tick.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  // Strobes from the bus decoder to the counter datapath
  typedef struct packed {
    logic clear;     // write hit: zero every tap
    logic advance;   // tick: count up by one
    logic readLoad;  // read hit: capture count onto read bus
  } tbStrobe_t;
endpackage

// File: rtl/tick_timebase_ctrl.sv
module tick_timebase_ctrl
  import tick_timebase_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0040
) (
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output tbStrobe_t         strb
);
  logic regHit;

  assign regHit = (addr == REG_ADDR);

  always_comb begin
    strb          = '0;
    strb.clear    = wrEn & regHit;
    strb.advance  = tickEn;
    strb.readLoad = rdEn & regHit;
  end
endmodule

// File: rtl/tick_timebase_datapath.sv
module tick_timebase_datapath
  import tick_timebase_pkg::*;
#(
  parameter int TAP_COUNT = 8,
  parameter int BUS_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tbStrobe_t            strb,
  input  logic [TAP_COUNT-1:0] irqEn,
  output logic [BUS_W-1:0]     rdData,
  output logic [TAP_COUNT-1:0] irqOut
);
  localparam int PAD_W = BUS_W - TAP_COUNT;
  localparam logic [TAP_COUNT-1:0] ONE = TAP_COUNT'(1);

  logic [TAP_COUNT-1:0] count;
  logic [TAP_COUNT-1:0] prevCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      prevCount <= '0;
      rdData    <= '0;
    end else begin
      prevCount <= count;
      if (strb.clear)
        count <= '0;
      else if (strb.advance)
        count <= count + ONE;
      rdData <= strb.readLoad ? {{PAD_W{1'b0}}, count} : '0;
    end
  end

  for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tapIrq
    assign irqOut[k] = prevCount[k] & ~count[k] & irqEn[k];
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear) |=> (count == $past(count) + ONE));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> $stable(count));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));
  // R7
  read_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readLoad |=> (rdData == {{PAD_W{1'b0}}, $past(count)}));
  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readLoad |=> (rdData == '0));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |=> ((irqOut & $past(irqOut)) == '0));
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tick_timebase_pkg::*;
#(
  parameter int TAP_COUNT = 8,
  parameter int BUS_W     = 16,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0040
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [BUS_W-1:0]     wrData,
  input  logic                 rdEn,
  output logic [BUS_W-1:0]     rdData,
  input  logic [TAP_COUNT-1:0] irqEn,
  output logic [TAP_COUNT-1:0] irqOut
);
  tbStrobe_t strb;
  logic      unusedData;

  // Write data is deliberately ignored: any write clears.
  assign unusedData = ^wrData;

  tick_timebase_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_ctrl (
    .tickEn(tickEn),
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .strb  (strb)
  );

  tick_timebase_datapath #(
    .TAP_COUNT(TAP_COUNT),
    .BUS_W    (BUS_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .irqEn (irqEn),
    .rdData(rdData),
    .irqOut(irqOut)
  );
endmodule

// File: tb/tb_tick_timebase.sv
module tb_tick_timebase;
  localparam int TAPS = 8;
  localparam int BUSW = 16;
  localparam int AW   = 16;
  localparam logic [AW-1:0] RA = 16'h0040;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0]   addr   = '0;
  logic [BUSW-1:0] wrData = '0;
  logic [TAPS-1:0] irqEn  = '0;
  logic [BUSW-1:0] rdData;
  logic [TAPS-1:0] irqOut;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int model = 0;

  always #5 clk = ~clk;

  tick_timebase #(.TAP_COUNT(TAPS), .BUS_W(BUSW), .ADDR_W(AW), .REG_ADDR(RA)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irqEn(irqEn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives for one cycle and returns at the next falling edge.
  task automatic cyc(input logic t, input logic w, input logic r,
                     input logic [AW-1:0] a, input logic [BUSW-1:0] d);
    tickEn = t; wrEn = w; rdEn = r; addr = a; wrData = d;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic readChk(input string req);
    cyc(1'b0, 1'b0, 1'b1, RA, '0);
    chk(req, 32'(rdData), 32'(model));
    chk("R2 hold irq", 32'(irqOut), 32'h0);
  endtask

  task automatic tickChk(input string req);
    int prev;
    prev = model;
    cyc(1'b1, 1'b0, 1'b0, RA, '0);
    model = (model + 1) & 255;
    chk(req, 32'(irqOut), 32'(prev & ~model & 32'(irqEn)));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdData", 32'(rdData), 32'h0);
    chk("R1 irq", 32'(irqOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readChk("R1 count");

    // Full sweeps with three enable masks (R2, R9, R11)
    irqEn = 8'hFF;
    for (int i = 0; i < 256; i++) begin tickChk("R9 all"); readChk("R2 sweep"); end
    irqEn = 8'hA5;
    for (int i = 0; i < 256; i++) begin tickChk("R9 mask"); readChk("R2 sweep"); end
    irqEn = 8'h00;
    for (int i = 0; i < 64; i++) begin tickChk("R11 off"); readChk("R2 sweep"); end

    // Clear from a nonzero value (R4, R10)
    irqEn = 8'hFF;
    while (model != 8'hB7) tickChk("R9 walk");
    cyc(1'b0, 1'b1, 1'b0, RA, 16'h1234);
    chk("R10 clear irq", 32'(irqOut), 32'hB7);
    model = 0;
    readChk("R4 clear");

    // R3: slowest tap rises after 128 ticks
    for (int i = 0; i < 127; i++) tickChk("R9 walk");
    readChk("R3 tap7 low");
    tickChk("R9 walk");
    cyc(1'b0, 1'b0, 1'b1, RA, '0);
    chk("R3 tap7 high", 32'(rdData[7]), 32'h1);
    chk("R3 tap0 low", 32'(rdData[0]), 32'h0);

    // R6: write elsewhere has no effect
    cyc(1'b0, 1'b1, 1'b0, RA, 16'h0);
    model = 0;
    for (int i = 0; i < 5; i++) tickChk("R9 walk");
    cyc(1'b0, 1'b1, 1'b0, RA + 16'h1, 16'hFFFF);
    chk("R6 irq", 32'(irqOut), 32'h0);
    readChk("R6 miss write");

    // R5: clear and tick together
    irqEn = 8'h0F;
    while (model != 8'h3C) tickChk("R9 walk");
    cyc(1'b1, 1'b1, 1'b0, RA, 16'h00FF);
    chk("R5 irq", 32'(irqOut), 32'h0C);
    model = 0;
    readChk("R5 clear wins");

    // R7: read during tick returns the old value
    for (int i = 0; i < 3; i++) tickChk("R9 walk");
    cyc(1'b1, 1'b0, 1'b1, RA, '0);
    chk("R7 read old", 32'(rdData), 32'h3);
    model = 4;
    readChk("R7 after");

    // R8: miss read and idle cycle
    cyc(1'b0, 1'b0, 1'b1, RA + 16'h2, '0);
    chk("R8 miss read", 32'(rdData), 32'h0);
    readChk("R7 again");
    cyc(1'b0, 1'b0, 1'b0, RA, '0);
    chk("R8 idle", 32'(rdData), 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule